// File: doc/BRIEF.md
# Parallel-Bus Host Controller for a Byte-Wide 12-bit Converter

This block is the host-side master for a 12-bit successive-approximation converter that shares one 8-bit data bus with its host. It sits behind a valid/ready request port. A request names the input channel, the range and polarity, whether acquisition is timed by the converter or by the host, and the power-down codes. The controller builds the configuration byte from these fields and writes it under chip-select. When the host times the acquisition, it issues a second write after a programmed gap. It then waits for the converter's active-low completion line and reads the result back in two byte reads.

The low byte is read with the byte-select strobe low and the high byte with it high. Only the low nibble of the high byte carries result bits. The controller returns the raw 12-bit code and a widened value. The widened value is sign-extended for bipolar requests and zero-extended for unipolar ones. The request port accepts nothing new until the previous response has been taken. If completion never arrives, a programmable watchdog ends the transaction with an error flag.

Top module: `adc_bus_host`

## Requirements
- R1: During and right after reset: chip-select, write and read strobes are high, byte-select is low, the bus driver is off, `req_ready` is high and `rsp_valid` is low.
- R2: The configuration byte holds the power-down code in bits 7:6, the acquisition-mode flag in bit 5 (1 = host-timed), the range in bit 4, the polarity in bit 3 (1 = bipolar) and the channel in bits 2:0. A converter-timed request produces exactly one write, with bit 5 = 0 and the first power-down code.
- R3: Each write holds the write strobe low for max(`cfg_wr_low`,1) cycles. The byte is driven, unchanged, for that time and for max(`cfg_wr_hold`,1) further cycles after the strobe rises. Chip-select stays low throughout.
- R4: A host-timed request produces two writes. The first has bit 5 = 1 and the first power-down code. The second has bit 5 = 0 and the second power-down code, with the same channel, range and polarity bits. The second write's strobe falls max(`cfg_wr_low`,1)+max(`cfg_wr_hold`,1)+max(`cfg_acq_gap`,1) cycles after the first one's.
- R5: After the conversion-starting write, the controller waits for `bus_int_n` low. It then performs a read with byte-select low, followed by one with byte-select high. Each read holds the read strobe low for max(`cfg_rd_low`,1) cycles, and the byte is sampled in the last of those cycles.
- R6: `rsp_code` is {high-byte bits 3:0, low byte}. High-byte bits 7:4 have no effect on any response field.
- R7: `rsp_value` equals `rsp_code` sign-extended from bit 11 when the request was bipolar, and zero-extended when it was unipolar.
- R8: If `bus_int_n` is not seen low within max(`cfg_timeout`,1) cycles of entering the wait, the response carries `rsp_timeout` = 1 and a zero code and value, with no read strobe issued.
- R9: `req_ready` is low from acceptance until the response is taken. `rsp_valid`, `rsp_code` and `rsp_timeout` hold steady while `rsp_ready` is low.
- R10: The read and write strobes are never low together. Neither is low while chip-select is high, and the bus driver is off whenever chip-select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| req_chan | input | 3 | Input channel select |
| req_range | input | 1 | Range select bit |
| req_bipolar | input | 1 | 1 = bipolar (two's complement) conversion |
| req_ext_acq | input | 1 | 1 = host-timed acquisition (two writes) |
| req_pd_first | input | 2 | Power-down code for the first write |
| req_pd_second | input | 2 | Power-down code for the second write |
| cfg_wr_low | input | CNT_W | Write strobe low time in cycles |
| cfg_wr_hold | input | CNT_W | Data hold after write strobe rises, cycles |
| cfg_acq_gap | input | CNT_W | Cycles between the two host-timed writes |
| cfg_rd_low | input | CNT_W | Read strobe low time / data-valid delay, cycles |
| cfg_timeout | input | TO_W | Completion wait limit in cycles |
| bus_cs_n | output | 1 | Chip-select, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_hben | output | 1 | Byte select: 1 = high byte |
| bus_d_out | output | 8 | Data driven toward the converter |
| bus_d_oe | output | 1 | Enable for the bus driver |
| bus_d_in | input | 8 | Data read from the bus |
| bus_int_n | input | 1 | Conversion complete, active low |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_code | output | 12 | Raw conversion code |
| rsp_value | output | OUT_W | Sign- or zero-extended code |
| rsp_timeout | output | 1 | Completion never arrived |

## Verification
A corrupt state register shows at the strobes within a cycle: a missing or extra write, a read with the wrong byte-select, or a strobe without chip-select. A miscount in the cycle timer lengthens or shortens a strobe, which the bench measures to the cycle on every transaction. A wrong acquisition-mode or second-write flag changes bit 5 or the power-down field of a written byte, or the number of writes. A lost capture or a wrong polarity bit shows as a wrong code or extension on the very next response.

// File: rtl/adcb_pkg.sv
package adcb_pkg;

   localparam int BYTE_W = 8;
   localparam int CODE_W = 12;
   localparam int CHAN_W = 3;
   localparam int PD_W   = 2;
   localparam int NIB_W  = CODE_W - BYTE_W;

   // bit positions the converter decodes
   localparam int BIT_BIP = 3;
   localparam int BIT_RNG = 4;
   localparam int BIT_ACQ = 5;
   localparam int PD_LSB  = 6;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WLOW,
      ST_WHOLD,
      ST_GAP,
      ST_WAIT,
      ST_RLO,
      ST_RMID,
      ST_RHI,
      ST_RESP
   } adcb_state_e;

   typedef struct packed {
      logic [CHAN_W-1:0] chan;
      logic              rng;
      logic              bip;
      logic              ext;
      logic [PD_W-1:0]   pd_a;
      logic [PD_W-1:0]   pd_b;
   } adcb_req_t;

endpackage

// File: rtl/adcb_ctrl_byte.sv
module adcb_ctrl_byte
   import adcb_pkg::*;
(
   input  adcb_req_t         req,
   input  logic              second,
   output logic [BYTE_W-1:0] byte_o
);

   always_comb begin
      byte_o                  = '0;
      byte_o[CHAN_W-1:0]      = req.chan;
      byte_o[BIT_BIP]         = req.bip;
      byte_o[BIT_RNG]         = req.rng;
      byte_o[BIT_ACQ]         = req.ext & ~second;
      byte_o[PD_LSB +: PD_W]  = second ? req.pd_b : req.pd_a;
   end

endmodule

// File: rtl/adcb_timer.sv
module adcb_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);

   generate
      if (W < 1) begin : g_bad_w
         $error("adcb_timer: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= (load_val == '0) ? '0 : load_val - 1'b1;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done = (cnt_q == '0);

   // R3: a nonzero count is only ever left by counting down or reloading
   a_r3_count_step : assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !done) |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/adcb_sync.sv
module adcb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES > 4) begin : g_bad_stages
         $error("adcb_sync: STAGES must be 0..4");
      end
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] r_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               r_q <= '1;
            end else begin
               r_q[0] <= d;
               for (int i = 1; i < STAGES; i++) begin
                  r_q[i] <= r_q[i-1];
               end
            end
         end
         assign q = r_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/adcb_result.sv
module adcb_result
   import adcb_pkg::*;
#(
   parameter int OUT_W = 16
) (
   input  logic [BYTE_W-1:0] lo,
   input  logic [NIB_W-1:0]  hi,
   input  logic              bip,
   output logic [CODE_W-1:0] code,
   output logic [OUT_W-1:0]  value
);

   localparam int EXT_W = OUT_W - CODE_W;

   assign code = {hi, lo};

   generate
      if (OUT_W < CODE_W) begin : g_bad_out
         $error("adcb_result: OUT_W must be at least 12");
      end else if (OUT_W == CODE_W) begin : g_same
         assign value = code;
      end else begin : g_wide
         assign value = bip ? {{EXT_W{code[CODE_W-1]}}, code}
                            : {{EXT_W{1'b0}}, code};
      end
   endgenerate

endmodule

// File: rtl/adc_bus_host.sv
module adc_bus_host
   import adcb_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int TO_W        = 16,
   parameter int SYNC_STAGES = 2,
   parameter int OUT_W       = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [2:0]       req_chan,
   input  logic             req_range,
   input  logic             req_bipolar,
   input  logic             req_ext_acq,
   input  logic [1:0]       req_pd_first,
   input  logic [1:0]       req_pd_second,
   input  logic [CNT_W-1:0] cfg_wr_low,
   input  logic [CNT_W-1:0] cfg_wr_hold,
   input  logic [CNT_W-1:0] cfg_acq_gap,
   input  logic [CNT_W-1:0] cfg_rd_low,
   input  logic [TO_W-1:0]  cfg_timeout,
   output logic             bus_cs_n,
   output logic             bus_wr_n,
   output logic             bus_rd_n,
   output logic             bus_hben,
   output logic [7:0]       bus_d_out,
   output logic             bus_d_oe,
   input  logic [7:0]       bus_d_in,
   input  logic             bus_int_n,
   output logic             rsp_valid,
   input  logic             rsp_ready,
   output logic [11:0]      rsp_code,
   output logic [OUT_W-1:0] rsp_value,
   output logic             rsp_timeout
);

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("adc_bus_host: CNT_W must be at least 1");
      end
      if (TO_W < 2) begin : g_bad_to
         $error("adc_bus_host: TO_W must be at least 2");
      end
      if (OUT_W < CODE_W) begin : g_bad_out
         $error("adc_bus_host: OUT_W must be at least 12");
      end
   endgenerate

   adcb_state_e state_q, state_d;
   adcb_req_t   req_q;
   logic        second_q;
   logic [BYTE_W-1:0] lo_q;
   logic [NIB_W-1:0]  hi_q;
   logic        to_q;

   logic        int_sync, int_low;
   logic        st_done, to_done;
   logic        st_load, to_load;
   logic [CNT_W-1:0]  st_val;
   logic [BYTE_W-1:0] ctrl_byte;

   // completion line into the clock domain
   adcb_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (bus_int_n),
      .q     (int_sync)
   );
   assign int_low = ~int_sync;

   adcb_ctrl_byte u_byte (
      .req    (req_q),
      .second (second_q),
      .byte_o (ctrl_byte)
   );

   // strobe-phase timer, reloaded on every state change
   always_comb begin
      case (state_d)
         ST_WLOW:  st_val = cfg_wr_low;
         ST_WHOLD: st_val = cfg_wr_hold;
         ST_GAP:   st_val = cfg_acq_gap;
         ST_RLO,
         ST_RHI:   st_val = cfg_rd_low;
         default:  st_val = '0;
      endcase
   end
   assign st_load = (state_d != state_q);

   adcb_timer #(.W(CNT_W)) u_st_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (st_load),
      .load_val (st_val),
      .done     (st_done)
   );

   assign to_load = (state_d == ST_WAIT) && (state_q != ST_WAIT);

   adcb_timer #(.W(TO_W)) u_to_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (to_load),
      .load_val (cfg_timeout),
      .done     (to_done)
   );

   // next-state logic
   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:  if (req_valid) state_d = ST_WLOW;
         ST_WLOW:  if (st_done) state_d = ST_WHOLD;
         ST_WHOLD: if (st_done) state_d = (req_q.ext && !second_q) ? ST_GAP : ST_WAIT;
         ST_GAP:   if (st_done) state_d = ST_WLOW;
         ST_WAIT: begin
            if (int_low)      state_d = ST_RLO;
            else if (to_done) state_d = ST_RESP;
         end
         ST_RLO:   if (st_done) state_d = ST_RMID;
         ST_RMID:  state_d = ST_RHI;
         ST_RHI:   if (st_done) state_d = ST_RESP;
         ST_RESP:  if (rsp_ready) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         req_q    <= '0;
         second_q <= 1'b0;
         lo_q     <= '0;
         hi_q     <= '0;
         to_q     <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && req_valid) begin
            req_q.chan <= req_chan;
            req_q.rng  <= req_range;
            req_q.bip  <= req_bipolar;
            req_q.ext  <= req_ext_acq;
            req_q.pd_a <= req_pd_first;
            req_q.pd_b <= req_pd_second;
            second_q   <= 1'b0;
         end
         if (state_q == ST_GAP && st_done) begin
            second_q <= 1'b1;
         end
         if (state_q == ST_RLO && st_done) begin
            lo_q <= bus_d_in;
         end
         if (state_q == ST_RHI && st_done) begin
            hi_q <= bus_d_in[NIB_W-1:0];
            to_q <= 1'b0;
         end
         if (state_q == ST_WAIT && !int_low && to_done) begin
            lo_q <= '0;
            hi_q <= '0;
            to_q <= 1'b1;
         end
      end
   end

   // bus strobes decoded from state
   assign bus_cs_n  = !(state_q inside {ST_WLOW, ST_WHOLD, ST_RLO, ST_RMID, ST_RHI});
   assign bus_wr_n  = (state_q != ST_WLOW);
   assign bus_rd_n  = !(state_q inside {ST_RLO, ST_RHI});
   assign bus_hben  = (state_q inside {ST_RMID, ST_RHI});
   assign bus_d_oe  = (state_q inside {ST_WLOW, ST_WHOLD});
   assign bus_d_out = bus_d_oe ? ctrl_byte : '0;

   assign req_ready   = (state_q == ST_IDLE);
   assign rsp_valid   = (state_q == ST_RESP);
   assign rsp_timeout = to_q;

   adcb_result #(.OUT_W(OUT_W)) u_res (
      .lo    (lo_q),
      .hi    (hi_q),
      .bip   (req_q.bip),
      .code  (rsp_code),
      .value (rsp_value)
   );

   a_r10_strobes_apart : assert property (@(posedge clk) disable iff (!rst_n)
      !(!bus_wr_n && !bus_rd_n));

   a_r10_strobe_under_cs : assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr_n || !bus_rd_n) |-> !bus_cs_n);

   a_r10_release_bus : assert property (@(posedge clk) disable iff (!rst_n)
      bus_cs_n |-> !bus_d_oe);

   a_r3_byte_steady : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_d_oe && $past(bus_d_oe) && !$past(bus_wr_n, 1) && !bus_wr_n) |-> $stable(bus_d_out));

   a_r9_busy_not_ready : assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   a_r9_rsp_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_code) && $stable(rsp_timeout)));

   a_r8_timeout_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_timeout) |-> (rsp_code == '0));

   a_r5_read_after_wait : assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bus_rd_n) && !bus_hben) |-> ($past(state_q) == ST_WAIT));

endmodule

// File: tb/sim_adc_bus_host.sv
`timescale 1ns/1ps
module sim_adc_bus_host;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [2:0]  req_chan = '0;
   logic        req_range = 1'b0, req_bipolar = 1'b0, req_ext_acq = 1'b0;
   logic [1:0]  req_pd_first = '0, req_pd_second = '0;
   logic [7:0]  cfg_wr_low = 8'd1, cfg_wr_hold = 8'd1, cfg_acq_gap = 8'd1, cfg_rd_low = 8'd1;
   logic [15:0] cfg_timeout = 16'd40;
   logic        bus_cs_n, bus_wr_n, bus_rd_n, bus_hben, bus_d_oe;
   logic [7:0]  bus_d_out, bus_d_in;
   logic        bus_int_n = 1'b1;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic [11:0] rsp_code;
   logic [15:0] rsp_value;
   logic        rsp_timeout;

   always #2.5 clk = ~clk;

   adc_bus_host u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_chan(req_chan), .req_range(req_range), .req_bipolar(req_bipolar),
      .req_ext_acq(req_ext_acq), .req_pd_first(req_pd_first), .req_pd_second(req_pd_second),
      .cfg_wr_low(cfg_wr_low), .cfg_wr_hold(cfg_wr_hold), .cfg_acq_gap(cfg_acq_gap),
      .cfg_rd_low(cfg_rd_low), .cfg_timeout(cfg_timeout),
      .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .bus_hben(bus_hben),
      .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe), .bus_d_in(bus_d_in), .bus_int_n(bus_int_n),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code),
      .rsp_value(rsp_value), .rsp_timeout(rsp_timeout)
   );

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // converter model
   logic [11:0] m_res = '0;
   logic        m_bip = 1'b0, m_garb = 1'b0, m_silent = 1'b0;
   int          conv_delay = 5;
   int          conv_cnt = 0;
   logic [3:0]  m_nib;
   assign m_nib = (m_bip ? {4{m_res[11]}} : 4'h0) ^ (m_garb ? 4'hA : 4'h0);
   assign bus_d_in = (!bus_cs_n && !bus_rd_n) ? (bus_hben ? {m_nib, m_res[11:8]} : m_res[7:0]) : 8'h00;

   int   nw = 0, nr = 0, cyc = 0;
   int   wfall [0:3];
   int   wlen  [0:3];
   int   oelen [0:3];
   logic [7:0] wbyte [0:3];
   int   rlen  [0:3];
   logic rhben [0:3];
   int   viol = 0, viol_hold = 0;
   logic prev_wr = 1'b1, prev_rd = 1'b1, prev_oe = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (conv_cnt > 0) begin
            conv_cnt--;
            if (conv_cnt == 0) bus_int_n <= 1'b0;
         end
         if (prev_oe && !bus_oe_now()) begin
            if (nw < 3) nw++;
         end
         if (!bus_wr_n && prev_wr) begin
            wfall[nw] = cyc; wlen[nw] = 0; oelen[nw] = 0;
         end
         if (!bus_wr_n) begin
            wlen[nw]++;
            wbyte[nw] = bus_d_out;
         end
         if (bus_d_oe) oelen[nw]++;
         if (bus_d_oe && bus_wr_n && bus_d_out != wbyte[nw]) viol_hold++;
         if (bus_wr_n && !prev_wr) begin
            bus_int_n <= 1'b1;
            if (!wbyte[nw][5] && !m_silent) conv_cnt = conv_delay;
         end
         if (!bus_rd_n && prev_rd) begin
            bus_int_n <= 1'b1;
            rhben[nr] = bus_hben; rlen[nr] = 0;
            if (nr < 3) nr++;
         end
         if (!bus_rd_n && nr > 0) rlen[nr-1]++;
         if (bus_cs_n && bus_d_oe) viol++;
         if (!bus_wr_n && !bus_rd_n) viol++;
         if ((!bus_wr_n || !bus_rd_n) && bus_cs_n) viol++;
         prev_wr = bus_wr_n; prev_rd = bus_rd_n; prev_oe = bus_d_oe;
      end
   end

   function automatic logic bus_oe_now();
      return bus_d_oe;
   endfunction

   function automatic int atl1(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   task automatic txn(input logic [2:0] ch, input logic rng, input logic bip, input logic ext,
                      input logic [1:0] pa, input logic [1:0] pb, input logic [11:0] res,
                      input logic garb, input logic silent,
                      input int n, input int h, input int g, input int r, input int to, input int hold);
      logic [7:0]  b0, b1;
      logic [11:0] ecode;
      logic [15:0] evalue;
      logic [11:0] code_seen;
      bit          busy_bad;
      @(negedge clk);
      m_res = res; m_bip = bip; m_garb = garb; m_silent = silent;
      cfg_wr_low = n[7:0]; cfg_wr_hold = h[7:0]; cfg_acq_gap = g[7:0]; cfg_rd_low = r[7:0];
      cfg_timeout = to[15:0];
      nw = 0; nr = 0;
      req_chan = ch; req_range = rng; req_bipolar = bip; req_ext_acq = ext;
      req_pd_first = pa; req_pd_second = pb; req_valid = 1'b1;
      chk(req_ready == 1'b1, "R9 ready when idle", req_ready, 1);
      @(negedge clk);
      req_valid = 1'b0;
      busy_bad = 0;
      while (!rsp_valid) begin
         if (req_ready) busy_bad = 1;
         @(negedge clk);
      end
      chk(!busy_bad, "R9 ready low while busy", busy_bad, 0);
      b0 = {pa, ext, rng, bip, ch};
      b1 = {pb, 1'b0, rng, bip, ch};
      chk(nw == (ext ? 2 : 1), ext ? "R4 write count" : "R2 write count", nw, ext ? 2 : 1);
      chk(wbyte[0] == b0, ext ? "R4 first byte" : "R2 control byte", wbyte[0], b0);
      chk(wlen[0] == atl1(n), "R3 write strobe length", wlen[0], atl1(n));
      chk(oelen[0] == atl1(n) + atl1(h), "R3 data drive length", oelen[0], atl1(n) + atl1(h));
      if (ext) begin
         chk(wbyte[1] == b1, "R4 second byte", wbyte[1], b1);
         chk(wlen[1] == atl1(n), "R3 second strobe length", wlen[1], atl1(n));
         chk(wfall[1] - wfall[0] == atl1(n) + atl1(h) + atl1(g), "R4 write spacing",
             wfall[1] - wfall[0], atl1(n) + atl1(h) + atl1(g));
      end
      if (silent) begin
         ecode = '0; evalue = '0;
         chk(nr == 0, "R8 no reads on timeout", nr, 0);
      end else begin
         ecode = res;
         evalue = bip ? {{4{res[11]}}, res} : {4'h0, res};
         chk(nr == 2, "R5 read count", nr, 2);
         chk(rhben[0] == 1'b0 && rhben[1] == 1'b1, "R5 byte order", {rhben[0], rhben[1]}, 2'b01);
         chk(rlen[0] == atl1(r) && rlen[1] == atl1(r), "R5 read strobe length", rlen[0], atl1(r));
      end
      chk(rsp_timeout == silent, "R8 timeout flag", rsp_timeout, silent);
      chk(rsp_code == ecode, garb ? "R6 code with noisy nibble" : "R6 code", rsp_code, ecode);
      chk(rsp_value == evalue, "R7 extended value", rsp_value, evalue);
      code_seen = rsp_code;
      for (int i = 0; i < hold; i++) @(negedge clk);
      chk(rsp_valid && rsp_code == code_seen, "R9 response held", rsp_code, code_seen);
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk(!rsp_valid && req_ready, "R9 released after accept", {rsp_valid, req_ready}, 2'b01);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(bus_cs_n && bus_wr_n && bus_rd_n, "R1 strobes idle in reset", {bus_cs_n, bus_wr_n, bus_rd_n}, 3'b111);
      chk(!bus_hben && !bus_d_oe, "R1 byte select and driver off", {bus_hben, bus_d_oe}, 0);
      chk(!rsp_valid, "R1 no response in reset", rsp_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready, "R1 ready after reset", req_ready, 1);
      chk(bus_cs_n && !bus_d_oe, "R1 bus released after reset", {bus_cs_n, bus_d_oe}, 2'b10);

      for (int ch = 0; ch < 8; ch++) begin
         for (int bp = 0; bp < 2; bp++) begin
            for (int ex = 0; ex < 2; ex++) begin
               int i;
               logic [11:0] rv;
               i = ch * 4 + bp * 2 + ex;
               rv = 12'((ch * 499 + bp * 2048 + ex * 165 + i * 37) % 4096);
               txn(ch[2:0], ch[0], bp[0], ex[0], 2'(i % 4), 2'((i + 1) % 4), rv,
                   (ch == 5), 1'b0, 1 + (i % 3), 1 + (i % 2), 2 + (i % 4), 1 + (i % 3), 40, i % 3);
            end
         end
      end
      // sign boundaries and zero-count fields
      txn(3'd2, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 12'h800, 1'b0, 1'b0, 0, 0, 0, 0, 40, 1);
      txn(3'd2, 1'b0, 1'b1, 1'b1, 2'd1, 2'd3, 12'h7FF, 1'b1, 1'b0, 2, 3, 5, 2, 40, 0);
      txn(3'd7, 1'b1, 1'b0, 1'b0, 2'd2, 2'd0, 12'hFFF, 1'b1, 1'b0, 3, 1, 1, 4, 40, 2);
      txn(3'd0, 1'b1, 1'b1, 1'b0, 2'd3, 2'd1, 12'h000, 1'b0, 1'b0, 1, 2, 1, 1, 40, 0);
      txn(3'd6, 1'b0, 1'b1, 1'b1, 2'd1, 2'd2, 12'hFFF, 1'b0, 1'b0, 1, 1, 0, 2, 40, 1);
      // completion never arrives
      txn(3'd4, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 12'h5A5, 1'b0, 1'b1, 1, 1, 1, 1, 20, 1);
      txn(3'd1, 1'b1, 1'b0, 1'b1, 2'd2, 2'd1, 12'h3C3, 1'b0, 1'b1, 2, 2, 3, 1, 0, 0);
      // normal transfer right after a timeout
      txn(3'd3, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 12'hABC, 1'b0, 1'b0, 1, 1, 1, 2, 40, 0);

      chk(viol == 0, "R10 strobe and release rules", viol, 0);
      chk(viol_hold == 0, "R3 byte steady during hold", viol_hold, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      finished = 1;
      $finish;
   end

   initial begin
      #500000;
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule